// File: doc/BRIEF.md
# Printer Port Register Emulator

This block is a byte-wide register file that behaves like a standard parallel printer port with a simulated printer behind it. A host reaches three registers through a small offset bus with separate read and write strobes. The three registers hold the outgoing data byte, the printer status and the port control. An extra input register captures a byte presented on a side input, and the host reads it back when the port is turned around for input.

The printer is not timed. Its busy/acknowledge handshake moves one step each time the host reads the status register. When the host raises the strobe bit through a control write, the block sends the current data byte out on a byte stream with a single-cycle valid pulse. A level interrupt output reports a pending acknowledge event while interrupts are enabled.

Top module: `prn_port_emu`

## Requirements
- R1: After reset the data read gives 0xFF, status reads 0xD8 (busy bit7, ack bit6, online bit4, error bit3), control reads 0x0C (select bit3, init bit2), and irq and tx_valid are low.
- R2: Offsets 3 to 7 read as 0xFF, and writes to them change no register. A write to offset 1 (status) also changes nothing.
- R3: A control write (offset 2) with bit2 (init) at 0 loads status with 0xD8.
- R4: A control write with init=1, select (bit3)=1 and strobe (bit0)=1 clears status bit7. If the stored strobe bit was 0, the data byte is presented on tx_data with tx_valid high for exactly one cycle, in the cycle after the write edge.
- R5: A strobe-high control write whose stored strobe bit was already 1 emits nothing.
- R6: A control write with init=1, select=1 and strobe=0 sets the interrupt pending flag only if the stored control value before the write had bit4 (interrupt enable) set.
- R7: irq is high exactly while the pending flag is set and stored control bit4 is 1. A status read (offset 1) clears the pending flag.
- R8: A status read returns status as it was before the read. After the read, if bit7 is 0 and the stored strobe bit is 0: when bit6 is 1 it is cleared, otherwise bits 7 and 6 are both set.
- R9: A data read (offset 0) returns the input register (loaded from in_data while in_load is high, reset 0xFF) when control bit5 is 1, and otherwise returns the last byte written to offset 0.
- R10: A control read returns the full 8-bit value last written to offset 2.
- R11: A control write with init=1 and select=0 leaves status unchanged and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects at the clock edge) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| in_data | input | 8 | Byte for the input register |
| in_load | input | 1 | Loads in_data into the input register |
| tx_data | output | 8 | Byte sent to the printer |
| tx_valid | output | 1 | One-cycle pulse marking tx_data |
| irq | output | 1 | Level interrupt |

## Verification
A wrong handshake state shows on the next status read: the byte returned at offset 1 differs from the bench's arithmetic model at once, and the error keeps going through the ack/busy cycle. A wrong stored strobe or enable bit shows one control write later, as a missing or extra tx_valid pulse or a wrong irq level, because those decisions use the old control value. A long sweep of control values, each followed by status reads, checks all of these after every single access.

// File: rtl/prn_pkg.sv
package prn_pkg;
   localparam int BYTE_W = 8;

   // status bit positions
   localparam int ST_BUSY   = 7;
   localparam int ST_ACK    = 6;
   localparam int ST_PAPER  = 5;
   localparam int ST_ONLINE = 4;
   localparam int ST_ERR    = 3;
   localparam int ST_TMO    = 0;

   // control bit positions
   localparam int CT_DIR  = 5;
   localparam int CT_IEN  = 4;
   localparam int CT_SEL  = 3;
   localparam int CT_INIT = 2;
   localparam int CT_ALF  = 1;
   localparam int CT_STB  = 0;

   localparam int OFF_DATA = 0;
   localparam int OFF_STAT = 1;
   localparam int OFF_CTRL = 2;

   localparam logic [BYTE_W-1:0] ST_IDLE   = 8'hD8;
   localparam logic [BYTE_W-1:0] CT_IDLE   = 8'h0C;
   localparam logic [BYTE_W-1:0] DATA_IDLE = 8'hFF;
   localparam logic [BYTE_W-1:0] UNMAPPED  = 8'hFF;

   typedef struct packed {
      logic init_load;
      logic busy_clr;
      logic emit;
      logic pend_set;
   } ctl_evt_t;
endpackage

// File: rtl/prn_ctl_decode.sv
module prn_ctl_decode
   import prn_pkg::*;
(
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] new_val,
   input  logic [BYTE_W-1:0] old_val,
   output ctl_evt_t          evt
);
   logic sel_ok;

   always_comb begin
      sel_ok         = new_val[CT_INIT] && new_val[CT_SEL];
      evt.init_load  = wr_ctrl && !new_val[CT_INIT];
      evt.busy_clr   = wr_ctrl && sel_ok && new_val[CT_STB];
      evt.emit       = wr_ctrl && sel_ok && new_val[CT_STB] && !old_val[CT_STB];
      evt.pend_set   = wr_ctrl && sel_ok && !new_val[CT_STB] && old_val[CT_IEN];
   end
endmodule

// File: rtl/prn_status_seq.sv
module prn_status_seq
   import prn_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_evt_t          evt,
   input  logic              rd_stat,
   input  logic              stb_q,
   output logic [BYTE_W-1:0] status_q
);
   logic [BYTE_W-1:0] status_d;

   always_comb begin
      status_d = status_q;
      if (evt.init_load)
         status_d = ST_IDLE;
      else if (evt.busy_clr)
         status_d[ST_BUSY] = 1'b0;
      else if (rd_stat && !status_q[ST_BUSY] && !stb_q) begin
         if (status_q[ST_ACK])
            status_d[ST_ACK] = 1'b0;
         else begin
            status_d[ST_ACK]  = 1'b1;
            status_d[ST_BUSY] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= ST_IDLE;
      else        status_q <= status_d;
   end

   p_init_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt.init_load |=> status_q == ST_IDLE);
   p_busy_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt.busy_clr |=> !status_q[ST_BUSY]);
   p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !status_q[ST_BUSY] && !stb_q && status_q[ST_ACK]) |=> !status_q[ST_ACK]);
   p_ack_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !status_q[ST_BUSY] && !stb_q && !status_q[ST_ACK])
      |=> (status_q[ST_ACK] && status_q[ST_BUSY]));
endmodule

// File: rtl/prn_irq_unit.sv
module prn_irq_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_set,
   input  logic rd_stat,
   input  logic ien,
   output logic irq
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (pend_set) pend_q <= 1'b1;
      else if (rd_stat)  pend_q <= 1'b0;
   end

   assign irq = pend_q && ien;

   p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set |=> pend_q);
   p_pend_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !pend_set) |=> !pend_q);
endmodule

// File: rtl/prn_port_emu.sv
module prn_port_emu
   import prn_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter bit TX_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        in_data,
   input  logic              in_load,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

   generate
      if (ADDR_W < 2) begin : g_addr_chk
         $error("prn_port_emu: ADDR_W must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] dataw_q, datar_q, ctrl_q, status_q;
   logic              wr_data, wr_ctrl, rd_stat;
   ctl_evt_t          evt;

   assign wr_data = bus_wr && (bus_addr == A_DATA);
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign rd_stat = bus_rd && (bus_addr == A_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dataw_q <= DATA_IDLE;
         datar_q <= DATA_IDLE;
         ctrl_q  <= CT_IDLE;
      end else begin
         if (wr_data) dataw_q <= bus_wdata;
         if (in_load) datar_q <= in_data;
         if (wr_ctrl) ctrl_q  <= bus_wdata;
      end
   end

   prn_ctl_decode u_dec (
      .wr_ctrl (wr_ctrl),
      .new_val (bus_wdata),
      .old_val (ctrl_q),
      .evt     (evt)
   );

   prn_status_seq u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .rd_stat  (rd_stat),
      .stb_q    (ctrl_q[CT_STB]),
      .status_q (status_q)
   );

   prn_irq_unit u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_set (evt.pend_set),
      .rd_stat  (rd_stat),
      .ien      (ctrl_q[CT_IEN]),
      .irq      (irq)
   );

   always_comb begin
      case (bus_addr)
         A_DATA:  bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
         A_STAT:  bus_rdata = status_q;
         A_CTRL:  bus_rdata = ctrl_q;
         default: bus_rdata = UNMAPPED;
      endcase
   end

   generate
      if (TX_REG) begin : g_tx_reg
         logic       txv_q;
         logic [7:0] txd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               txv_q <= 1'b0;
               txd_q <= DATA_IDLE;
            end else begin
               txv_q <= evt.emit;
               if (evt.emit) txd_q <= dataw_q;
            end
         end
         assign tx_valid = txv_q;
         assign tx_data  = txd_q;

         p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid |=> !tx_valid);
      end else begin : g_tx_comb
         assign tx_valid = evt.emit;
         assign tx_data  = dataw_q;
      end
   endgenerate

   p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr > A_CTRL)) |=> ($stable(ctrl_q) && $stable(dataw_q)));
   p_stat_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_STAT) && !bus_rd) |=> $stable(status_q));
endmodule

// File: tb/sim_prn_port_emu.sv
module sim_prn_port_emu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, in_load = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, in_data = '0;
   logic [7:0] bus_rdata, tx_data;
   logic       tx_valid, irq;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] m_dw = 8'hFF, m_dr = 8'hFF, m_st = 8'hD8, m_ct = 8'h0C;
   logic       m_pend = 1'b0;

   always #5 clk = ~clk;

   prn_port_emu u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .in_data(in_data), .in_load(in_load), .tx_data(tx_data),
      .tx_valid(tx_valid), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [2:0] a);
      case (a)
         3'd0:    return m_ct[5] ? m_dr : m_dw;
         3'd1:    return m_st;
         3'd2:    return m_ct;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic wr(input logic [2:0] a, input logic [7:0] v, input string req);
      logic exp_tx = 1'b0;
      logic [7:0] exp_byte = m_dw;
      if (a == 3'd0) m_dw = v;
      if (a == 3'd2) begin
         if (!v[2]) m_st = 8'hD8;
         else if (v[3]) begin
            if (v[0]) begin
               m_st[7] = 1'b0;
               exp_tx = !m_ct[0];
            end else if (m_ct[4]) m_pend = 1'b1;
         end
         m_ct = v;
      end
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      chk({req, " tx_valid"}, {7'd0, tx_valid}, {7'd0, exp_tx});
      if (exp_tx) chk({req, " tx_data"}, tx_data, exp_byte);
      chk({req, " irq (R7)"}, {7'd0, irq}, {7'd0, m_pend & m_ct[4]});
      @(posedge clk); #1;
      chk({req, " tx pulse end"}, {7'd0, tx_valid}, 8'd0);
   endtask

   task automatic rd(input logic [2:0] a, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2;
      chk(req, bus_rdata, model_read(a));
      if (a == 3'd1) begin
         m_pend = 1'b0;
         if (!m_st[7] && !m_ct[0]) begin
            if (m_st[6]) m_st[6] = 1'b0;
            else m_st = m_st | 8'hC0;
         end
      end
      @(posedge clk); #1;
      bus_rd = 1'b0;
      chk({req, " irq (R7)"}, {7'd0, irq}, {7'd0, m_pend & m_ct[4]});
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
      chk("R1 irq", {7'd0, irq}, 8'd0);
      rd(3'd0, "R1 data");
      rd(3'd1, "R1 status");
      rd(3'd2, "R1 control");

      // R2 unmapped offsets and status write
      for (int a = 3; a < 8; a++) rd(3'(a), "R2 unmapped read");
      for (int a = 3; a < 8; a++) wr(3'(a), 8'h00, "R2");
      wr(3'd1, 8'h00, "R2");
      rd(3'd0, "R2 data kept");
      rd(3'd1, "R2 status kept");
      rd(3'd2, "R2 control kept");

      // R9 direction
      @(negedge clk); in_data = 8'h5A; in_load = 1'b1;
      @(negedge clk); in_load = 1'b0; m_dr = 8'h5A;
      rd(3'd0, "R9 dir out");
      wr(3'd0, 8'h33, "R9");
      wr(3'd2, 8'h2C, "R9");
      rd(3'd0, "R9 dir in");
      wr(3'd2, 8'h0C, "R9");
      rd(3'd0, "R9 dir out again");

      // R4 / R5 emission
      wr(3'd0, 8'hA5, "R4");
      wr(3'd2, 8'h0D, "R4");
      rd(3'd1, "R4 busy cleared");
      wr(3'd2, 8'h0D, "R5");

      // R8 handshake sequence
      wr(3'd2, 8'h0C, "R8");
      rd(3'd1, "R8 read a");
      rd(3'd1, "R8 read b");
      rd(3'd1, "R8 read c");

      // R3 init load
      wr(3'd2, 8'h0D, "R3");
      wr(3'd2, 8'h08, "R3");
      rd(3'd1, "R3 status");

      // R6 / R7 interrupt
      wr(3'd2, 8'h1C, "R6 no old enable");
      wr(3'd2, 8'h1C, "R6 old enable");
      wr(3'd2, 8'h0C, "R7 mask");
      wr(3'd2, 8'h1C, "R7 unmask");
      rd(3'd1, "R7 clear");

      // R11 select low
      wr(3'd2, 8'h0C, "R11");
      wr(3'd2, 8'h05, "R11");
      rd(3'd1, "R11 status");

      // R10 full control readback
      wr(3'd2, 8'hE7, "R10");
      rd(3'd2, "R10 control");

      // sweep over control patterns with model comparison
      for (int i = 0; i < 400; i++) begin
         if ((i % 5) == 0) wr(3'd0, 8'((i * 29 + 7) & 8'hFF), "R4 sweep");
         wr(3'd2, 8'((i * 37 + 11) & 8'h3F), "R4 R6 sweep");
         rd(3'd1, "R8 sweep");
         if ((i % 3) == 0) rd(3'd1, "R8 sweep 2");
         rd(3'd0, "R9 sweep");
         rd(3'd2, "R10 sweep");
      end

      done = 1'b1;
      finish_up();
   end
endmodule